// File: doc/BRIEF.md
# Byte FIFO with Water-Level Alerts

This block is a 64-deep, byte-wide first-in first-out store that a host reaches through one data port: asserting `push` stores `wdata`, and asserting `pop` removes the oldest byte, which is always visible on `rdata` while the store holds data. A 7-bit occupancy count runs from 0 to 64 and is readable at all times.

A single 6-bit threshold, `level`, sets two status flags. `hi_alert` warns that little free space is left. `lo_alert` warns that little data is left. A rising edge on either flag also yields a one-cycle event pulse for an interrupt controller.

Requests that cannot be honoured are dropped and recorded in sticky error flags: a push into a full store, or a pop from an empty one. A `flush` input empties the store in one cycle.

Top module: `byte_fifo_alert`

## Requirements
- R1: After reset `fill` is 0, `lo_alert` is 1, `hi_alert` is 0, both error flags are 0 and neither event pulse is high.
- R2: A push while `fill` < 64 stores `wdata` and raises `fill` by one after the clock edge; a pop while `fill` > 0 lowers it by one; `fill` never exceeds 64.
- R3: A push while `fill` = 64 is ignored (contents and count unchanged) and sets `ovf_err`, which stays 1 until a flush.
- R4: A pop while `fill` = 0 is ignored (count stays 0) and sets `udf_err`, which stays 1 until a flush.
- R5: A push and a pop in the same cycle with 0 < `fill` < 64 leave `fill` unchanged and keep byte order; at `fill` = 64 only the pop takes effect, and at `fill` = 0 only the push takes effect.
- R6: `hi_alert` is 1 exactly when (64 − `fill`) ≤ `level`; with `level` = 4, a fill of 60 gives 1 and a fill of 59 gives 0.
- R7: `lo_alert` is 1 exactly when `fill` ≤ `level`; with `level` = 4, a fill of 4 gives 1 and a fill of 5 gives 0.
- R8: `hi_evt` and `lo_evt` are high for exactly one cycle after the clock edge at which the matching alert turns from 0 to 1, and are low otherwise.
- R9: `flush` takes priority over `push` and `pop`. It sets `fill` to 0, restarts both pointers and clears both error flags in one cycle.
- R10: While `fill` > 0, `rdata` shows the oldest stored byte; bytes leave in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the store and clear the errors |
| push | input | 1 | Store `wdata` |
| wdata | input | 8 | Byte to store |
| pop | input | 1 | Remove the oldest byte |
| rdata | output | 8 | Oldest stored byte |
| level | input | 6 | Threshold for both alerts |
| fill | output | 7 | Number of stored bytes |
| hi_alert | output | 1 | Free space at or below the threshold |
| lo_alert | output | 1 | Occupancy at or below the threshold |
| hi_evt | output | 1 | One-cycle pulse on a rising `hi_alert` |
| lo_evt | output | 1 | One-cycle pulse on a rising `lo_alert` |
| ovf_err | output | 1 | Sticky: push into full store |
| udf_err | output | 1 | Sticky: pop from empty store |

## Verification
The count is registered and both alerts decode directly from it. A wrong count therefore shows at `fill` and at the alert pins right after the edge that corrupted it, and a wrong alert edge shows at the event pins in that same cycle. A pointer fault leaves the count correct but shows at `rdata` on the next pop that reaches the damaged slot. The bench compares every byte popped against a reference queue, so that fault surfaces within at most 64 pops. Random traffic with a random threshold is run in phases that bias toward full, toward empty and toward balance, so that both boundaries and both rejection cases recur often.

// File: rtl/byte_fifo_alert.sv
module byte_fifo_alert #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int LW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  input  logic [LW-1:0] level,
  output logic [$clog2(DEPTH):0] fill,
  output logic          hi_alert,
  output logic          lo_alert,
  output logic          hi_evt,
  output logic          lo_evt,
  output logic          ovf_err,
  output logic          udf_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          hi_q, lo_q;

  wire full   = (count == FULL_C);
  wire empty  = (count == '0);
  wire wr_ok  = push && !full && !flush;
  wire rd_ok  = pop && !empty && !flush;
  wire [CW-1:0] free_sp = FULL_C - count;

  assign fill     = count;
  assign rdata    = mem[rd_ptr];
  assign hi_alert = (free_sp <= CW'(level));
  assign lo_alert = (count <= CW'(level));
  assign hi_evt   = hi_alert && !hi_q;
  assign lo_evt   = lo_alert && !lo_q;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      ovf_err <= 1'b0;
      udf_err <= 1'b0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b1;
    end else begin
      hi_q <= hi_alert;
      lo_q <= lo_alert;
      if (flush) begin
        wr_ptr  <= '0;
        rd_ptr  <= '0;
        count   <= '0;
        ovf_err <= 1'b0;
        udf_err <= 1'b0;
      end else begin
        if (wr_ok) wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
        if (rd_ok) rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
        if (wr_ok && !rd_ok)      count <= count + 1'b1;
        else if (rd_ok && !wr_ok) count <= count - 1'b1;
        if (push && full) ovf_err <= 1'b1;
        if (pop && empty) udf_err <= 1'b1;
      end
    end
  end

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_C);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !flush |=> full && ovf_err);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err && !flush |=> ovf_err);
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !flush |=> empty && udf_err);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !full && !empty && !flush |=> $stable(count));
  p_hi_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_evt |=> !hi_evt);
  p_lo_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_evt |=> !lo_evt);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !ovf_err && !udf_err);
endmodule

// File: tb/byte_fifo_alert_tb.sv
module byte_fifo_alert_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, push = 1'b0, pop = 1'b0;
  logic [7:0] wdata = '0;
  logic [5:0] level = '0;
  logic [7:0] rdata;
  logic [6:0] fill;
  logic       hi_alert, lo_alert, hi_evt, lo_evt, ovf_err, udf_err;

  int checks = 0, failures = 0;
  byte unsigned q[$];
  bit m_ovf = 0, m_udf = 0;

  always #5 clk = ~clk;

  byte_fifo_alert u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .wdata(wdata),
    .pop(pop), .rdata(rdata), .level(level), .fill(fill),
    .hi_alert(hi_alert), .lo_alert(lo_alert), .hi_evt(hi_evt), .lo_evt(lo_evt),
    .ovf_err(ovf_err), .udf_err(udf_err));

  function automatic bit exp_hi(int f, int lv);
    return (64 - f) <= lv;
  endfunction
  function automatic bit exp_lo(int f, int lv);
    return f <= lv;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit p, bit r, bit f, byte unsigned d, int lv);
    int  old_n;
    bit  ph, pl, w_ok, r_ok;
    @(negedge clk);
    push = p; pop = r; flush = f; wdata = d; level = 6'(lv);
    #1;
    old_n = q.size();
    if (old_n > 0) chk("R10 rdata head", rdata, q[0]);
    ph = exp_hi(old_n, lv);
    pl = exp_lo(old_n, lv);
    w_ok = p && !f && old_n < 64;
    r_ok = r && !f && old_n > 0;
    @(posedge clk);
    if (f) begin
      q.delete(); m_ovf = 0; m_udf = 0;
    end else begin
      if (r_ok) void'(q.pop_front());
      if (w_ok) q.push_back(d);
      if (p && old_n == 64) m_ovf = 1;
      if (r && old_n == 0) m_udf = 1;
    end
    #1;
    chk("R2 fill", fill, q.size());
    chk("R6 hi_alert", hi_alert, exp_hi(q.size(), lv));
    chk("R7 lo_alert", lo_alert, exp_lo(q.size(), lv));
    chk("R8 hi_evt", hi_evt, exp_hi(q.size(), lv) && !ph);
    chk("R8 lo_evt", lo_evt, exp_lo(q.size(), lv) && !pl);
    chk("R3 ovf_err", ovf_err, m_ovf);
    chk("R4 udf_err", udf_err, m_udf);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    level = 6'd4;
    #23;
    // R1 reset state
    chk("R1 fill", fill, 0);
    chk("R1 lo_alert", lo_alert, 1);
    chk("R1 hi_alert", hi_alert, 0);
    chk("R1 errors", ovf_err | udf_err, 0);
    chk("R1 events", hi_evt | lo_evt, 0);
    rst_n = 1'b1;
    // R2/R6/R7 fill to full with level 4, crossing 4/5 and 59/60
    for (int i = 0; i < 64; i++) cyc(1, 0, 0, 8'(i * 3 + 1), 4);
    // R3 push while full is ignored
    cyc(1, 0, 0, 8'hAA, 4);
    cyc(1, 0, 0, 8'hBB, 4);
    // R5 push+pop while full: only pop
    cyc(1, 1, 0, 8'hCC, 4);
    cyc(1, 1, 0, 8'hDD, 4);
    // R10 drain all, crossing boundaries again
    while (q.size() > 0) cyc(0, 1, 0, 8'h00, 4);
    // R4 pop while empty
    cyc(0, 1, 0, 8'h00, 4);
    // R5 push+pop while empty: only push
    cyc(1, 1, 0, 8'h5A, 4);
    cyc(1, 1, 0, 8'h5B, 4);
    // R9 flush overrides push and clears errors
    cyc(1, 0, 1, 8'h77, 4);
    chk("R9 fill after flush", fill, 0);
    chk("R9 errors cleared", ovf_err | udf_err, 0);
    // level extremes
    for (int i = 0; i < 64; i++) cyc(1, 0, 0, 8'(i), 63);
    cyc(0, 0, 0, 8'h00, 0);
    cyc(0, 1, 0, 8'h00, 0);
    cyc(0, 0, 1, 8'h00, 0);
    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      int pw = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 15 : 50;
      int pr = 100 - pw;
      int lv = $urandom_range(63, 0);
      for (int k = 0; k < 400; k++) begin
        bit p = ($urandom_range(99, 0) < pw);
        bit r = ($urandom_range(99, 0) < pr) || ($urandom_range(9, 0) == 0);
        bit f = ($urandom_range(255, 0) == 0);
        if ($urandom_range(63, 0) == 0) lv = $urandom_range(63, 0);
        cyc(p, r, f, 8'($urandom), lv);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule